// File: doc/BRIEF.md
# Single-Entry Jump Target Cache

This block sits beside the instruction prefetcher. It keeps the first two instruction words found at the destination of the last cache-loading jump that was taken. When that same jump is taken again, which is what a tight loop does, the block hands both words to the prefetch queue one cycle later, so the loop does not wait for slow memory.

The decoder reports each jump with the jump's own address, its target, a kind code and a taken flag. A miss by a taken relative, absolute or bit-test jump starts a fill. The fill reads two consecutive words from the fetch port and sets the entry valid only after the second word is in. The control-flow unit raises a flush for an inter-segment jump, call or return, a software trap, an interrupt return or an interrupt acceptance. A flush clears the entry and aborts any fill in progress. A stall input freezes the fill while the bus serves an interleaved transfer.

Top module: `jtc_top`

## Requirements
- R1: A taken jump whose kind code is 0 (relative), 1 (absolute), 2 (bit test), 3 (bit test and clear) or 4 (bit test and set), and which does not hit, raises `mem_req` with `mem_addr` equal to the jump target after the same clock edge.
- R2: A fill reads the word at the target and then the word at target+1, one accepted read (`mem_req` and `mem_rvalid` both high) per word. The entry only becomes valid after the second word has been accepted. A repeat of the jump before that point does not hit.
- R3: A taken jump of a kind from R1, with `jmp_pc` equal to the stored jump address while the entry is valid, pulses `hit_valid` one cycle later. In that cycle `hit_word0` holds the memory word at the target and `hit_word1` the word at target+1, and `mem_req` stays low.
- R4: Kind codes 5 (intra-segment call), 6 (intra-segment return) and 7 (other intra-segment transfer), and not-taken jumps of any kind, neither fill nor hit. A valid entry survives them.
- R5: `cf_flush` clears the entry. It takes priority over a jump in the same cycle, which then neither hits nor fills.
- R6: `cf_flush` during a fill drops `mem_req` after the next edge and leaves the entry invalid.
- R7: While `stall` is high, a fill in progress keeps `mem_req` and `mem_addr` unchanged and ignores `mem_rvalid` and `mem_rdata`.
- R8: Synchronous reset clears the entry, `hit_valid` and `mem_req`.
- R9: A taken loading jump at a new address that misses replaces the entry. A later repeat of the jump at the old address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jmp_valid | input | 1 | A decoded jump event is present |
| jmp_kind | input | 3 | Jump kind code (see R1, R4) |
| jmp_taken | input | 1 | Branch condition true |
| jmp_pc | input | AW | Address of the jump instruction |
| jmp_tgt | input | AW | Jump target address |
| cf_flush | input | 1 | Invalidate entry (inter-segment transfer, trap, interrupt return or entry) |
| stall | input | 1 | Freeze the fill state machine |
| mem_req | output | 1 | Fill read request |
| mem_addr | output | AW | Fill read word address |
| mem_rdata | input | DW | Fetched instruction word |
| mem_rvalid | input | 1 | Read data valid this cycle |
| hit_valid | output | 1 | Cached words are presented |
| hit_word0 | output | DW | Word at the cached target |
| hit_word1 | output | DW | Word at target+1 |

## Verification
Every cycle, the embedded assertions check four things: a hit never coincides with an outstanding fill request, the valid bit only rises right after a completed fill, a flush leaves the entry invalid and the request low, and a stalled fill holds its request and address. Only the bench scenarios can show whether the delivered words equal memory contents. The same holds for the two-iteration loop that hits, for a loop broken by an interrupt-style flush that misses, for survival across intra-segment calls, and for the rejection of garbage data presented during a stall.

// File: rtl/jtc_pkg.sv
package jtc_pkg;

  typedef enum logic [2:0] {
    JK_REL     = 3'd0,
    JK_ABS     = 3'd1,
    JK_BIT     = 3'd2,
    JK_BIT_CLR = 3'd3,
    JK_BIT_SET = 3'd4,
    JK_CALL    = 3'd5,
    JK_RET     = 3'd6,
    JK_OTHER   = 3'd7
  } jmp_kind_e;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_READ = 1'b1
  } fill_state_e;

  function automatic logic is_loader(input logic [2:0] kind);
    return kind <= JK_BIT_SET;
  endfunction

endpackage

// File: rtl/jtc_tag.sv
module jtc_tag #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lookup,
  input  logic [AW-1:0] pc,
  input  logic          flush,
  input  logic          fill_start,
  input  logic          fill_done,
  output logic          hit,
  output logic          valid
);

  logic [AW-1:0] tag_q;
  logic          valid_q;

  assign hit   = lookup && valid_q && (pc == tag_q) && !flush;
  assign valid = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (flush) begin
      valid_q <= 1'b0;
    end else if (fill_start) begin
      valid_q <= 1'b0;
      tag_q   <= pc;
    end else if (fill_done) begin
      valid_q <= 1'b1;
    end
  end

  AST_VALID_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(fill_done)); // R2

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> !valid_q); // R5

endmodule

// File: rtl/jtc_fill.sv
module jtc_fill #(
  parameter int AW = 16,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] tgt,
  input  logic          flush,
  input  logic          stall,
  input  logic          rvalid,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [LW-1:0] we,
  output logic          done
);
  import jtc_pkg::*;

  localparam int IW = (LW > 1) ? $clog2(LW) : 1;

  fill_state_e   state_q;
  logic [IW-1:0] idx_q;
  logic          take;
  logic          last;

  assign take = (state_q == FS_READ) && rvalid && !stall && !flush && !start;
  assign last = (idx_q == IW'(LW - 1));
  assign done = take && last;

  for (genvar i = 0; i < LW; i++) begin : g_we
    assign we[i] = take && (idx_q == IW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= FS_IDLE;
      idx_q      <= '0;
      mem_req_o  <= 1'b0;
      mem_addr_o <= '0;
    end else if (flush) begin
      state_q   <= FS_IDLE;
      mem_req_o <= 1'b0;
    end else if (start) begin
      state_q    <= FS_READ;
      idx_q      <= '0;
      mem_req_o  <= 1'b1;
      mem_addr_o <= tgt;
    end else if (take) begin
      if (last) begin
        state_q   <= FS_IDLE;
        mem_req_o <= 1'b0;
      end else begin
        idx_q      <= idx_q + IW'(1);
        mem_addr_o <= mem_addr_o + AW'(1);
      end
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && stall && !flush && !start) |=> (mem_req_o && $stable(mem_addr_o))); // R7

  AST_FLUSH_ABORTS: assert property (@(posedge clk) disable iff (rst)
    flush |=> !mem_req_o); // R6

endmodule

// File: rtl/jtc_data.sv
module jtc_data #(
  parameter int DW = 16,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] we,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  output logic          out_valid,
  output logic [DW-1:0] out_words [LW]
);

  logic [DW-1:0] store [LW];

  for (genvar i = 0; i < LW; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (we[i]) store[i] <= wdata;
    end
    always_ff @(posedge clk) begin
      if (rd_en) out_words[i] <= store[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= rd_en;
  end

endmodule

// File: rtl/jtc_top.sv
module jtc_top #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          jmp_valid,
  input  logic [2:0]    jmp_kind,
  input  logic          jmp_taken,
  input  logic [AW-1:0] jmp_pc,
  input  logic [AW-1:0] jmp_tgt,
  input  logic          cf_flush,
  input  logic          stall,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_rvalid,
  output logic          hit_valid,
  output logic [DW-1:0] hit_word0,
  output logic [DW-1:0] hit_word1
);
  import jtc_pkg::*;

  localparam int LW = 2;

  logic          lookup;
  logic          hit;
  logic          entry_valid;
  logic          fill_start;
  logic          fill_done;
  logic [LW-1:0] we;
  logic [DW-1:0] words [LW];

  assign lookup     = jmp_valid && jmp_taken && is_loader(jmp_kind);
  assign fill_start = lookup && !hit && !cf_flush;

  jtc_tag #(.AW(AW)) u_tag (
    .clk        (clk),
    .rst        (rst),
    .lookup     (lookup),
    .pc         (jmp_pc),
    .flush      (cf_flush),
    .fill_start (fill_start),
    .fill_done  (fill_done),
    .hit        (hit),
    .valid      (entry_valid)
  );

  jtc_fill #(.AW(AW), .LW(LW)) u_fill (
    .clk        (clk),
    .rst        (rst),
    .start      (fill_start),
    .tgt        (jmp_tgt),
    .flush      (cf_flush),
    .stall      (stall),
    .rvalid     (mem_rvalid),
    .mem_req_o  (mem_req),
    .mem_addr_o (mem_addr),
    .we         (we),
    .done       (fill_done)
  );

  jtc_data #(.DW(DW), .LW(LW)) u_data (
    .clk       (clk),
    .rst       (rst),
    .we        (we),
    .wdata     (mem_rdata),
    .rd_en     (hit),
    .out_valid (hit_valid),
    .out_words (words)
  );

  assign hit_word0 = words[0];
  assign hit_word1 = words[1];

  AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    hit_valid |-> !mem_req); // R3

  AST_FILL_INVALID: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !entry_valid); // R2

endmodule

// File: tb/sim_jtc_top.sv
`timescale 1ns/1ps
module sim_jtc_top;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NV = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          jmp_valid = 1'b0;
  logic [2:0]    jmp_kind = 3'd0;
  logic          jmp_taken = 1'b0;
  logic [AW-1:0] jmp_pc = '0;
  logic [AW-1:0] jmp_tgt = '0;
  logic          cf_flush = 1'b0;
  logic          stall = 1'b0;
  logic          mem_ok = 1'b1;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic          mem_rvalid;
  logic          hit_valid;
  logic [DW-1:0] hit_word0;
  logic [DW-1:0] hit_word1;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] mw(input logic [AW-1:0] a);
    return a ^ 16'hA5C3;
  endfunction

  assign mem_rdata  = stall ? 16'hDEAD : mw(mem_addr);
  assign mem_rvalid = mem_req && mem_ok;

  jtc_top #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .jmp_valid(jmp_valid), .jmp_kind(jmp_kind),
    .jmp_taken(jmp_taken), .jmp_pc(jmp_pc), .jmp_tgt(jmp_tgt),
    .cf_flush(cf_flush), .stall(stall), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .hit_valid(hit_valid),
    .hit_word0(hit_word0), .hit_word1(hit_word1)
  );

  // {kind[3], taken, pc[16], tgt[16], gap[4], expected hit}
  localparam logic [40:0] VEC [NV] = '{
    {3'd0, 1'b1, 16'h0100, 16'h00F0, 4'd3, 1'b0},
    {3'd0, 1'b1, 16'h0100, 16'h00F0, 4'd1, 1'b1},
    {3'd5, 1'b1, 16'h0200, 16'h0400, 4'd1, 1'b0},
    {3'd6, 1'b1, 16'h0410, 16'h0201, 4'd1, 1'b0},
    {3'd0, 1'b1, 16'h0100, 16'h00F0, 4'd1, 1'b1},
    {3'd2, 1'b0, 16'h0100, 16'h00F0, 4'd1, 1'b0},
    {3'd0, 1'b1, 16'h0100, 16'h00F0, 4'd1, 1'b1},
    {3'd1, 1'b1, 16'h0300, 16'h1234, 4'd3, 1'b0},
    {3'd1, 1'b1, 16'h0300, 16'h1234, 4'd1, 1'b1},
    {3'd0, 1'b1, 16'h0100, 16'h00F0, 4'd3, 1'b0},
    {3'd3, 1'b1, 16'h0500, 16'h0777, 4'd3, 1'b0},
    {3'd3, 1'b1, 16'h0500, 16'h0777, 4'd1, 1'b1},
    {3'd4, 1'b1, 16'h0600, 16'h0888, 4'd3, 1'b0},
    {3'd7, 1'b1, 16'h0600, 16'h0999, 4'd1, 1'b0},
    {3'd4, 1'b1, 16'h0600, 16'h0888, 4'd1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one jump for one edge; returns at the next negedge
  task automatic jump(input logic [2:0] k, input logic t, input logic [15:0] pc,
                      input logic [15:0] tg, input logic fl);
    @(negedge clk);
    jmp_valid = 1'b1; jmp_kind = k; jmp_taken = t; jmp_pc = pc; jmp_tgt = tg;
    cf_flush = fl;
    @(negedge clk);
    jmp_valid = 1'b0; cf_flush = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [15:0] tg);
    chk(hit_valid === 1'b1, req, "hit_valid", {31'd0, hit_valid}, 32'd1);
    chk(hit_word0 === mw(tg), req, "hit_word0", {16'd0, hit_word0}, {16'd0, mw(tg)});
    chk(hit_word1 === mw(tg + 16'd1), req, "hit_word1", {16'd0, hit_word1}, {16'd0, mw(tg + 16'd1)});
    chk(mem_req === 1'b0, req, "mem_req on hit", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic expect_miss_fill(input string req, input logic [15:0] tg);
    chk(hit_valid === 1'b0, req, "hit_valid", {31'd0, hit_valid}, 32'd0);
    chk(mem_req === 1'b1, req, "mem_req", {31'd0, mem_req}, 32'd1);
    chk(mem_addr === tg, req, "mem_addr", {16'd0, mem_addr}, {16'd0, tg});
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk(hit_valid === 1'b0, "R8", "hit_valid after reset", {31'd0, hit_valid}, 32'd0);
    chk(mem_req === 1'b0, "R8", "mem_req after reset", {31'd0, mem_req}, 32'd0);

    // table walk: R1 R3 R4 R9
    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      logic        ef;
      v = VEC[i];
      jump(v[40:38], v[37], v[36:21], v[20:5], 1'b0);
      ef = (v[40:38] <= 3'd4) && v[37] && !v[0];
      if (v[0]) expect_hit("R3", v[20:5]);
      else if (ef) expect_miss_fill("R1", v[20:5]);
      else begin
        chk(hit_valid === 1'b0, "R4", "no hit", {31'd0, hit_valid}, 32'd0);
        chk(mem_req === 1'b0, "R4", "no fill", {31'd0, mem_req}, 32'd0);
      end
      idle(int'(v[4:1]));
    end

    // R8: reset drops the valid entry at pc 0600
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    jump(3'd4, 1'b1, 16'h0600, 16'h0888, 1'b0);
    expect_miss_fill("R8", 16'h0888);
    idle(3);

    // R5: loop broken by interrupt-style flush
    jump(3'd0, 1'b1, 16'h0700, 16'h0710, 1'b0);
    idle(3);
    @(negedge clk); cf_flush = 1'b1;
    @(negedge clk); cf_flush = 1'b0;
    jump(3'd0, 1'b1, 16'h0700, 16'h0710, 1'b0);
    expect_miss_fill("R5", 16'h0710);
    idle(3);
    // R5: flush in the same cycle as a would-be hit
    jump(3'd0, 1'b1, 16'h0700, 16'h0710, 1'b1);
    chk(hit_valid === 1'b0, "R5", "hit with flush", {31'd0, hit_valid}, 32'd0);
    chk(mem_req === 1'b0, "R5", "fill with flush", {31'd0, mem_req}, 32'd0);
    jump(3'd0, 1'b1, 16'h0700, 16'h0710, 1'b0);
    expect_miss_fill("R5", 16'h0710);
    idle(3);

    // R6: flush during fill
    jump(3'd0, 1'b1, 16'h0800, 16'h0820, 1'b0);
    cf_flush = 1'b1;
    @(negedge clk); cf_flush = 1'b0;
    chk(mem_req === 1'b0, "R6", "mem_req after abort", {31'd0, mem_req}, 32'd0);
    idle(3);
    jump(3'd0, 1'b1, 16'h0800, 16'h0820, 1'b0);
    expect_miss_fill("R6", 16'h0820);
    idle(3);
    jump(3'd0, 1'b1, 16'h0800, 16'h0820, 1'b0);
    expect_hit("R6", 16'h0820);

    // R7: stall in the middle of a fill, bus shows garbage meanwhile
    jump(3'd0, 1'b1, 16'h0900, 16'h0A00, 1'b0);
    stall = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(mem_req === 1'b1, "R7", "mem_req held", {31'd0, mem_req}, 32'd1);
      chk(mem_addr === 16'h0A00, "R7", "mem_addr held", {16'd0, mem_addr}, 32'h0A00);
    end
    stall = 1'b0;
    idle(3);
    jump(3'd0, 1'b1, 16'h0900, 16'h0A00, 1'b0);
    expect_hit("R7", 16'h0A00);

    // R2: slow memory, repeat before second word arrives
    mem_ok = 1'b0;
    jump(3'd0, 1'b1, 16'h0B00, 16'h0B40, 1'b0);
    mem_ok = 1'b1;
    @(negedge clk); mem_ok = 1'b0;
    chk(mem_addr === 16'h0B41, "R2", "second word address", {16'd0, mem_addr}, 32'h0B41);
    chk(mem_req === 1'b1, "R2", "still filling", {31'd0, mem_req}, 32'd1);
    jump(3'd0, 1'b1, 16'h0B00, 16'h0B40, 1'b0);
    expect_miss_fill("R2", 16'h0B40);
    mem_ok = 1'b1;
    idle(3);
    jump(3'd0, 1'b1, 16'h0B00, 16'h0B40, 1'b0);
    expect_hit("R2", 16'h0B40);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule